// File: doc/BRIEF.md
# Serial Master Clock Baud Generator

This block makes the serial clock for a synchronous serial master, used either as an SPI master or as an I2C master. A reloadable down-counter paces the clock. It decrements on an enable that fires on every second system clock cycle. Each time the counter passes zero it reloads from an 8-bit period value and toggles the serial clock line. Two such rollovers make one full clock period, so the output frequency is the system clock divided by four times (period value plus one). For example, a 16 MHz clock with a period value of 9 gives 400 kHz.

A write to the transmit buffer starts the generator. A transfer-done indication from the surrounding mode logic stops it, and the clock line then keeps the level it last had. The mode logic also supplies a reload-enable. While this enable is low, the counter waits at zero and does not toggle the line. In I2C mode the smallest period values cannot be used. The block replaces any of them with the smallest legal value and raises an error flag that stays set.

Top module: `sclk_baud_gen`

## Requirements
- R1: After a synchronous reset, `sclk` sits at its idle level and `roll_stb` and `cfg_err` are low. The idle level is 1 when `mode_sel` is 4'b1000 (I2C master) and equals `spi_cpol` for any other `mode_sel` value (SPI master). No edge appears on `sclk` until a start.
- R2: While running, the counter steps down once every two system clock cycles. Each half-period of `sclk` therefore lasts 2*(E+1) cycles, where E is the effective period value.
- R3: A `buf_wr` pulse while idle starts the generator with the current period value. The first toggle of `sclk` is seen 2*(E+1) cycles after the clock edge that sampled `buf_wr`.
- R4: A `buf_wr` pulse while the generator is running is ignored: the current half-period keeps its length.
- R5: A `xfer_done` pulse stops the generator at the next clock edge and takes priority over a start in the same cycle. After that, `sclk` keeps its level and `roll_stb` stays low until the next start.
- R6: `roll_stb` is a single-cycle pulse that is high exactly in the cycle after `sclk` toggles.
- R7: In I2C mode, a period value of 0, 1 or 2 is replaced by 3 at each load. Such a load sets `cfg_err`, which then stays high until reset.
- R8: In SPI mode, every period value from 0 to 255 is used unchanged and `cfg_err` is not affected. A value of 0 gives a half-period of 2 cycles.
- R9: A new `reload_val` takes effect only at the next load. A half-period already under way keeps the value it was loaded with.
- R10: When the counter reaches zero while `reload_en` is low, it waits there with no toggle and no strobe. The toggle happens on the first prescaler enable after `reload_en` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 4 | Mode field; 4'b1000 selects I2C master, other values select SPI master |
| spi_cpol | input | 1 | Idle clock level in SPI mode |
| reload_val | input | 8 | Period value loaded at each start and each rollover |
| reload_en | input | 1 | Reload permission from the mode logic |
| buf_wr | input | 1 | Transmit buffer write strobe; starts the generator when idle |
| xfer_done | input | 1 | Operation complete; stops the generator |
| sclk | output | 1 | Serial clock line |
| roll_stb | output | 1 | One-cycle pulse after each rollover toggle |
| cfg_err | output | 1 | Sticky flag for an illegal I2C period value |

## Verification
The hardest states to reach are a stall at zero with reload permission withheld, and a period value changed in the middle of a half-period. The bench reaches the stall by dropping `reload_en` right after a strobe and keeping it low for much longer than the countdown takes. It then releases it and checks that the toggle follows within one prescaler step. Random runs change `reload_val` one cycle after the start and sometimes add a second buffer write part way through. The first interval must then match the old value, and the second interval the new one.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_I2C_MST = 4'b1000;
  localparam int I2C_MIN_RELOAD = 3;

  function automatic logic is_i2c(input logic [MODE_W-1:0] m);
    return m == MODE_I2C_MST;
  endfunction

  function automatic logic idle_level(input logic [MODE_W-1:0] m, input logic cpol);
    return is_i2c(m) ? 1'b1 : cpol;
  endfunction
endpackage

// File: rtl/sbg_prescale.sv
module sbg_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] ph_q;

      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          ph_q <= '0;
        end else if (run) begin
          if (ph_q == LAST) ph_q <= '0;
          else              ph_q <= ph_q + CW'(1);
        end
      end

      assign tick = run && (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sbg_reload_sel.sv
module sbg_reload_sel
  import sbg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [W-1:0]      raw_val,
  output logic [W-1:0]      eff_val,
  output logic              illegal
);
  localparam logic [W-1:0] FLOOR = W'(I2C_MIN_RELOAD);

  function automatic logic [W-1:0] clamp_val(input logic i2c, input logic [W-1:0] v);
    return (i2c && (v < FLOOR)) ? FLOOR : v;
  endfunction

  always_comb begin
    illegal = is_i2c(mode_sel) && (raw_val < FLOOR);
    eff_val = clamp_val(is_i2c(mode_sel), raw_val);
  end
endmodule

// File: rtl/sbg_halfcnt.sv
module sbg_halfcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_ok,
  input  logic         stop,
  input  logic         tick,
  input  logic         reload_en,
  input  logic [W-1:0] load_val,
  input  logic         idle_lvl,
  output logic         run_q,
  output logic [W-1:0] cnt_q,
  output logic         sclk_q,
  output logic         stb_q,
  output logic         fire
);
  logic at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    fire    = run_q && tick && at_zero && reload_en && !stop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sclk_q <= idle_lvl;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (stop) begin
        run_q <= 1'b0;
      end else if (start_ok) begin
        run_q <= 1'b1;
        cnt_q <= load_val;
      end else if (run_q && tick) begin
        if (!at_zero) begin
          cnt_q <= cnt_q - W'(1);
        end else if (reload_en) begin
          cnt_q  <= load_val;
          sclk_q <= ~sclk_q;
          stb_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sclk_baud_gen.sv
module sclk_baud_gen
  import sbg_pkg::*;
#(
  parameter int RLD_W   = 8,
  parameter int PRE_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              spi_cpol,
  input  logic [RLD_W-1:0]  reload_val,
  input  logic              reload_en,
  input  logic              buf_wr,
  input  logic              xfer_done,
  output logic              sclk,
  output logic              roll_stb,
  output logic              cfg_err
);
  logic             run_q;
  logic             tick;
  logic             start_ok;
  logic             fire;
  logic             load_evt;
  logic             illegal;
  logic [RLD_W-1:0] eff_val;
  logic [RLD_W-1:0] cnt_q;
  logic             idle_lvl;
  logic             err_q;

  assign start_ok = buf_wr && !run_q && !xfer_done;
  assign idle_lvl = idle_level(mode_sel, spi_cpol);

  sbg_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_ok),
    .run  (run_q),
    .tick (tick)
  );

  sbg_reload_sel #(.W(RLD_W)) u_sel (
    .mode_sel(mode_sel),
    .raw_val (reload_val),
    .eff_val (eff_val),
    .illegal (illegal)
  );

  sbg_halfcnt #(.W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .stop     (xfer_done),
    .tick     (tick),
    .reload_en(reload_en),
    .load_val (eff_val),
    .idle_lvl (idle_lvl),
    .run_q    (run_q),
    .cnt_q    (cnt_q),
    .sclk_q   (sclk),
    .stb_q    (roll_stb),
    .fire     (fire)
  );

  assign load_evt = start_ok || fire;

  always_ff @(posedge clk) begin
    if (!rst_n)                  err_q <= 1'b0;
    else if (load_evt && illegal) err_q <= 1'b1;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/sbg_chk.sv
module sbg_chk
  import sbg_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_sel,
  input logic              xfer_done,
  input logic              sclk,
  input logic              roll_stb,
  input logic              cfg_err,
  input logic              run_q,
  input logic              tick,
  input logic              load_evt,
  input logic [W-1:0]      cnt_q
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    roll_stb |=> !roll_stb); // R6
  AST_STB_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && roll_stb) |-> (sclk != $past(sclk))); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(run_q)) |-> $stable(sclk)); // R5
  AST_DONE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !run_q); // R5
  AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !roll_stb); // R5
  AST_I2C_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && mode_sel == MODE_I2C_MST) |=> (cnt_q >= W'(I2C_MIN_RELOAD))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_err)) |-> cfg_err); // R7
endmodule

bind sclk_baud_gen sbg_chk #(.W(RLD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .xfer_done(xfer_done),
  .sclk     (sclk),
  .roll_stb (roll_stb),
  .cfg_err  (cfg_err),
  .run_q    (run_q),
  .tick     (tick),
  .load_evt (load_evt),
  .cnt_q    (cnt_q)
);

// File: tb/sclk_baud_gen_tb_top.sv
module sclk_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_sel = 4'b1000;
  logic       spi_cpol = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic       reload_en = 1'b1;
  logic       buf_wr = 1'b0;
  logic       xfer_done = 1'b0;
  logic       sclk, roll_stb, cfg_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit exp_err = 1'b0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  sclk_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .spi_cpol(spi_cpol),
    .reload_val(reload_val), .reload_en(reload_en), .buf_wr(buf_wr),
    .xfer_done(xfer_done), .sclk(sclk), .roll_stb(roll_stb), .cfg_err(cfg_err)
  );

  function automatic int half_len(input bit i2c, input int v);
    int e;
    e = (i2c && v < 3) ? 3 : v;
    return 2 * (e + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_reset(input logic [3:0] m, input logic pol);
    @(negedge clk);
    mode_sel = m; spi_cpol = pol; rst_n = 1'b0;
    buf_wr = 1'b0; xfer_done = 1'b0; reload_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_err = 1'b0;
  endtask

  // Issue a start; returns at mid-cycle after the sampling edge.
  task automatic start_gen(input int v);
    @(negedge clk);
    reload_val = 8'(v); buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  // Cycles until roll_stb is seen; optional new value at cycle 1, optional extra write.
  task automatic wait_stb(output int n, input int new_v, input int poke_at);
    n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      buf_wr = (n == poke_at);
      if (n == 1 && new_v >= 0) reload_val = 8'(new_v);
      if (roll_stb || n > 3000) break;
    end
    buf_wr = 1'b0;
  endtask

  task automatic stop_and_hold(input int span, input string req);
    logic lvl;
    int stb_cnt;
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    lvl = sclk; stb_cnt = 0;
    for (int i = 0; i < span; i++) begin
      @(posedge clk); #1;
      if (roll_stb) stb_cnt++;
      if (sclk != lvl) stb_cnt += 100;
    end
    chk(stb_cnt == 0, req, stb_cnt, 0);
  endtask

  initial begin
    int n;
    int n2;
    logic lvl;
    void'($urandom(32'h5EED));

    // R1: reset idle levels
    do_reset(4'b1000, 1'b0);
    #1;
    chk(sclk == 1'b1, "R1 i2c idle", sclk, 1);
    chk(roll_stb == 1'b0 && cfg_err == 1'b0, "R1 stb/err low", {roll_stb, cfg_err}, 0);
    lvl = sclk; n = 0;
    repeat (20) begin @(posedge clk); #1; if (sclk != lvl || roll_stb) n++; end
    chk(n == 0, "R1 no edges before start", n, 0);
    do_reset(4'b0001, 1'b1); #1;
    chk(sclk == 1'b1, "R1 spi cpol1 idle", sclk, 1);
    do_reset(4'b0000, 1'b0); #1;
    chk(sclk == 1'b0, "R1 spi cpol0 idle", sclk, 0);

    // R8: SPI value 0 and 255
    start_gen(0);
    wait_stb(n, -1, 0);
    chk(n == 2, "R8 spi v0 first", n, 2);
    chk(sclk == 1'b1, "R6 level after toggle", sclk, 1);
    wait_stb(n, -1, 0);
    chk(n == 2, "R8 spi v0 second", n, 2);
    stop_and_hold(10, "R5 hold after stop");
    chk(cfg_err == 1'b0, "R8 no err in spi", cfg_err, 0);
    start_gen(255);
    wait_stb(n, -1, 0);
    chk(n == 512, "R8 spi v255", n, 512);
    stop_and_hold(10, "R5 hold after stop");

    // R3/R2: I2C value 9
    mode_sel = 4'b1000;
    start_gen(9);
    wait_stb(n, -1, 0);
    chk(n == 20, "R3 first toggle delay", n, 20);
    wait_stb(n, -1, 0);
    chk(n == 20, "R2 half period", n, 20);
    stop_and_hold(50, "R5 frozen line");
    chk(cfg_err == 1'b0, "R7 legal value no err", cfg_err, 0);

    // R7: I2C clamp and sticky error
    start_gen(1);
    wait_stb(n, -1, 0);
    chk(n == 8, "R7 clamp to 3", n, 8);
    chk(cfg_err == 1'b1, "R7 err set", cfg_err, 1);
    stop_and_hold(10, "R5 hold after stop");
    start_gen(9);
    wait_stb(n, -1, 0);
    chk(cfg_err == 1'b1, "R7 err sticky", cfg_err, 1);
    stop_and_hold(10, "R5 hold after stop");
    exp_err = 1'b1;

    // R4: write while running ignored
    start_gen(20);
    wait_stb(n, -1, 10);
    chk(n == 42, "R4 extra write ignored", n, 42);
    stop_and_hold(10, "R5 hold after stop");

    // R9: new value only at next load
    start_gen(5);
    wait_stb(n, 11, 0);
    chk(n == 12, "R9 old value kept", n, 12);
    wait_stb(n, -1, 0);
    chk(n == 24, "R9 new value at reload", n, 24);
    stop_and_hold(10, "R5 hold after stop");

    // R10: stall at zero without reload permission
    mode_sel = 4'b0010;
    start_gen(2);
    wait_stb(n, -1, 0);
    reload_en = 1'b0;
    lvl = sclk; n2 = 0;
    repeat (60) begin @(posedge clk); #1; if (roll_stb || sclk != lvl) n2++; end
    chk(n2 == 0, "R10 no toggle while held", n2, 0);
    reload_en = 1'b1;
    wait_stb(n, -1, 0);
    chk(n >= 1 && n <= 2, "R10 toggle after release", n, 2);
    stop_and_hold(10, "R5 hold after stop");

    // Random runs
    for (int it = 0; it < 30; it++) begin
      bit i2c;
      int v1, v2, pk;
      i2c = $urandom_range(0, 1);
      mode_sel = i2c ? 4'b1000 : 4'($urandom_range(0, 3));
      v1 = $urandom_range(0, 12);
      v2 = $urandom_range(0, 12);
      pk = $urandom_range(0, 1) ? $urandom_range(2, 6) : 0;
      @(negedge clk);
      lvl = sclk;
      start_gen(v1);
      wait_stb(n, v2, pk);
      chk(n == half_len(i2c, v1), "R2 random first half", n, half_len(i2c, v1));
      chk(sclk == ~lvl, "R6 random toggle", sclk, ~lvl);
      if (i2c && v1 < 3) exp_err = 1'b1;
      wait_stb(n, -1, 0);
      chk(n == half_len(i2c, v2), "R9 random second half", n, half_len(i2c, v2));
      if (i2c && v2 < 3) exp_err = 1'b1;
      chk(cfg_err == exp_err, "R7 random err flag", cfg_err, exp_err);
      stop_and_hold(8, "R5 random hold");
    end

    finish_run();
  end
endmodule